// File: doc/BRIEF.md
# Fixed-Timing Legacy Peripheral Bus Cycle Master

This block turns one host request at a time into a complete read or write cycle on an ISA-compatible parallel peripheral bus, of the kind still used to reach UARTs and CAN controllers. The host raises a one-cycle request along with four things: the direction, an I/O-or-memory space select, a byte-or-word width select and an address. A write request also carries its data. The block then raises `busy` and runs the bus cycle. A read finishes with a one-cycle `rd_valid` pulse that presents the captured data.

The bus timing is fixed by parameters and cannot be changed at run time. With a 99 MHz clock (one tick is about 10.1 ns), the cycle runs through three phases. The address is set up for 33 ticks. The command strobe is then held low for 50 ticks. A further 10 ticks follow, used as write-data hold or read recovery. In total a cycle lasts 93 ticks, or close to 1 µs.

Write data starts 4 ticks before the strobe falls. Read data is latched on the clock edge at which the strobe returns high. The data bus is presented as separate input, output and per-byte-lane enable signals.

Top module: `isa_cycle_master`

## Requirements
- R1: After reset, all four strobes (`ior_n`, `iow_n`, `memr_n`, `memw_n`) are high, `busy` is 0, `bus_doe` is 0 and `rd_valid` is 0.
- R2: A request sampled while idle is accepted on that clock edge. `busy` is high in the 93 cycles after that edge (k = 0..92) and low from k = 93 on. Here k counts clock edges after the accepting edge. `bus_addr` carries the request address from k = 0 and stays stable while `busy` is high.
- R3: Exactly one strobe goes low, and only for k = 33..82 (50 cycles). The strobe is chosen as follows:
  - `ior_n` for an I/O read (`req_wr`=0, `req_mem`=0)
  - `iow_n` for an I/O write (1, 0)
  - `memr_n` for a memory read (0, 1)
  - `memw_n` for a memory write (1, 1)
- R4: On a write, `bus_doe` is active for k = 29..92. That is 4 cycles before the strobe falls, through the strobe, and 10 cycles after it rises. During that window `bus_dout` carries the request write data.
- R5: On a read, `bus_din` is captured on the clock edge at which the strobe rises (the edge ending cycle k = 82). `rd_valid` pulses for exactly one cycle at k = 93, and `rd_data` then holds the captured value.
- R6: `bus_doe` is all zero whenever `ior_n` or `memr_n` is low, and for the whole of every read cycle.
- R7: `bus_doe[0]` enables data bits [7:0] and `bus_doe[1]` enables bits [15:8]. With `req_wide`=0 only bit 0 of `bus_doe` is driven, and `rd_data[15:8]` reads as zero. With `req_wide`=1 both lanes are driven and captured.
- R8: A request raised while `busy` is high is ignored. It changes neither the address, strobe, data nor timing of the running cycle, and it starts no cycle afterwards.
- R9: The cycle length and phase boundaries are the same for all four access types and both widths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (99 MHz nominal) |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | One-cycle access request |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_mem | input | 1 | 1 = memory space, 0 = I/O space |
| req_wide | input | 1 | 1 = 16-bit access, 0 = 8-bit |
| req_addr | input | ADDR_W | Access address |
| req_wdata | input | DATA_W | Write data |
| busy | output | 1 | High while a cycle is in progress |
| rd_data | output | DATA_W | Captured read data |
| rd_valid | output | 1 | One-cycle pulse when read data is ready |
| bus_addr | output | ADDR_W | Bus address |
| bus_dout | output | DATA_W | Data driven onto the bus |
| bus_doe | output | DATA_W/8 | Per-byte-lane output enable |
| bus_din | input | DATA_W | Data sampled from the bus |
| ior_n | output | 1 | I/O read strobe, active low |
| iow_n | output | 1 | I/O write strobe, active low |
| memr_n | output | 1 | Memory read strobe, active low |
| memw_n | output | 1 | Memory write strobe, active low |

## Verification
Every result is due at a fixed offset k, counted in clock edges after the accepting edge:
- `busy` rises at k = 0.
- Write data is enabled at k = 29.
- The strobe is low from k = 33 to 82.
- The read sample is taken at the edge after k = 82.
- `busy` falls and `rd_valid` pulses at k = 93.

The bench samples at each falling clock edge and compares every output against a per-k expectation computed from these offsets. Read data is presented as the correct value only in cycles k = 79..82 and as its complement otherwise, so a capture one edge early or late returns the wrong word. A stray request at k = 40 and idle checks at k = 94..95 show that requests made while busy leave no trace.

// File: rtl/isa_cyc_pkg.sv
package isa_cyc_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_STROBE = 2'd2,
        PH_HOLD   = 2'd3
    } phase_t;

    typedef struct packed {
        logic wr;
        logic mem;
        logic wide;
    } kind_t;

    // Active-low strobe vector {ior_n, iow_n, memr_n, memw_n}
    function automatic logic [3:0] strobe_decode(kind_t k, logic active);
        logic [3:0] s;
        s = 4'b1111;
        if (active) begin
            unique case ({k.mem, k.wr})
                2'b00: s = 4'b0111;
                2'b01: s = 4'b1011;
                2'b10: s = 4'b1101;
                default: s = 4'b1110;
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/isa_cyc_seq.sv
module isa_cyc_seq
    import isa_cyc_pkg::*;
#(
    parameter int ADDR_SETUP = 33,
    parameter int DATA_SETUP = 4,
    parameter int STROBE_LEN = 50,
    parameter int HOLD_LEN   = 10
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    output phase_t phase,
    output logic   drive_early,
    output logic   capture,
    output logic   done
);
    localparam int MAX_A = (ADDR_SETUP > STROBE_LEN) ? ADDR_SETUP : STROBE_LEN;
    localparam int MAX_L = (MAX_A > HOLD_LEN) ? MAX_A : HOLD_LEN;
    localparam int CW    = $clog2(MAX_L + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    cnt <= '0;
                    if (start) phase <= PH_SETUP;
                end
                PH_SETUP: begin
                    if (cnt == CW'(ADDR_SETUP - 1)) begin
                        phase <= PH_STROBE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_STROBE: begin
                    if (cnt == CW'(STROBE_LEN - 1)) begin
                        phase <= PH_HOLD;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    if (cnt == CW'(HOLD_LEN - 1)) begin
                        phase <= PH_IDLE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            endcase
        end
    end

    assign drive_early = (phase == PH_SETUP) && (cnt >= CW'(ADDR_SETUP - DATA_SETUP));
    assign capture     = (phase == PH_STROBE) && (cnt == CW'(STROBE_LEN - 1));
    assign done        = (phase == PH_HOLD) && (cnt == CW'(HOLD_LEN - 1));

    // R9: a strobe phase is only ever entered from a full setup phase
    p_setup_to_strobe_r9: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_STROBE && $past(phase) != PH_STROBE) |-> $past(phase) == PH_SETUP);

endmodule

// File: rtl/isa_cyc_datapath.sv
module isa_cyc_datapath
    import isa_cyc_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  kind_t             req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  phase_t            phase,
    input  logic              drive_early,
    input  logic              capture,
    input  logic              done,
    input  logic [DATA_W-1:0] bus_din,
    output kind_t             kind_q,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_dout,
    output logic [DATA_W/8-1:0] bus_doe,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    localparam int LANES = DATA_W / 8;

    logic drive_win;

    always_ff @(posedge clk) begin
        if (rst) begin
            kind_q   <= '0;
            bus_addr <= '0;
            bus_dout <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= done && !kind_q.wr;
            if (start) begin
                kind_q   <= req_kind;
                bus_addr <= req_addr;
                bus_dout <= req_wdata;
            end
        end
    end

    assign drive_win = kind_q.wr &&
        (drive_early || phase == PH_STROBE || phase == PH_HOLD);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        if (g == 0) begin : g_low
            assign bus_doe[g] = drive_win;
            always_ff @(posedge clk) begin
                if (rst)          rd_data[7:0] <= '0;
                else if (capture) rd_data[7:0] <= bus_din[7:0];
            end
        end else begin : g_high
            assign bus_doe[g] = drive_win && kind_q.wide;
            always_ff @(posedge clk) begin
                if (rst)
                    rd_data[g*8 +: 8] <= '0;
                else if (capture)
                    rd_data[g*8 +: 8] <= kind_q.wide ? bus_din[g*8 +: 8] : 8'h00;
            end
        end
    end

    // R7: a byte-wide read never returns a nonzero upper byte
    p_narrow_upper_zero_r7: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && !kind_q.wide) |-> rd_data[DATA_W-1:8] == '0);

    // R7: upper lane is never enabled without the lower lane
    p_lane_order_r7: assert property (@(posedge clk) disable iff (rst)
        (bus_doe[LANES-1] |-> bus_doe[0]));

endmodule

// File: rtl/isa_cycle_master.sv
module isa_cycle_master
    import isa_cyc_pkg::*;
#(
    parameter int ADDR_W     = 20,
    parameter int DATA_W     = 16,
    parameter int ADDR_SETUP = 33,
    parameter int DATA_SETUP = 4,
    parameter int STROBE_LEN = 50,
    parameter int HOLD_LEN   = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              req_wr,
    input  logic              req_mem,
    input  logic              req_wide,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_dout,
    output logic [DATA_W/8-1:0] bus_doe,
    input  logic [DATA_W-1:0] bus_din,
    output logic              ior_n,
    output logic              iow_n,
    output logic              memr_n,
    output logic              memw_n
);
    phase_t phase;
    logic   start, drive_early, capture, done;
    kind_t  req_kind, kind_q;
    logic [3:0] strobes_n;

    assign req_kind = '{wr: req_wr, mem: req_mem, wide: req_wide};
    assign start    = req && (phase == PH_IDLE);
    assign busy     = (phase != PH_IDLE);

    isa_cyc_seq #(
        .ADDR_SETUP(ADDR_SETUP), .DATA_SETUP(DATA_SETUP),
        .STROBE_LEN(STROBE_LEN), .HOLD_LEN(HOLD_LEN)
    ) u_seq (
        .clk(clk), .rst(rst), .start(start), .phase(phase),
        .drive_early(drive_early), .capture(capture), .done(done)
    );

    isa_cyc_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
        .clk(clk), .rst(rst), .start(start), .req_kind(req_kind),
        .req_addr(req_addr), .req_wdata(req_wdata), .phase(phase),
        .drive_early(drive_early), .capture(capture), .done(done),
        .bus_din(bus_din), .kind_q(kind_q), .bus_addr(bus_addr),
        .bus_dout(bus_dout), .bus_doe(bus_doe), .rd_data(rd_data),
        .rd_valid(rd_valid)
    );

    assign strobes_n = strobe_decode(kind_q, phase == PH_STROBE);
    assign {ior_n, iow_n, memr_n, memw_n} = strobes_n;

    // R3: never more than one strobe low
    p_single_strobe_r3: assert property (@(posedge clk) disable iff (rst)
        $countones(strobes_n) >= 3);

    // R6: no data drive while a read strobe is low
    p_no_drive_on_read_r6: assert property (@(posedge clk) disable iff (rst)
        (!ior_n || !memr_n) |-> bus_doe == '0);

    // R2: address held for the whole busy window
    p_addr_stable_r2: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(bus_addr));

    // R5: read-data pulse only once the cycle is over
    p_valid_after_cycle_r5: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> (!busy && $fell(busy)));

    // R8: a request while busy does not restart the cycle
    p_busy_ignores_req_r8: assert property (@(posedge clk) disable iff (rst)
        (busy && phase != PH_HOLD) |=> busy);

endmodule

// File: tb/sim_isa_cycle_master.sv
module sim_isa_cycle_master;
    localparam int AW = 20;
    localparam int DW = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req = 1'b0, req_wr = 1'b0, req_mem = 1'b0, req_wide = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [DW-1:0] bus_din = '0;
    logic busy, rd_valid, ior_n, iow_n, memr_n, memw_n;
    logic [DW-1:0] rd_data, bus_dout;
    logic [AW-1:0] bus_addr;
    logic [1:0] bus_doe;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    isa_cycle_master u0 (
        .clk(clk), .rst(rst), .req(req), .req_wr(req_wr), .req_mem(req_mem),
        .req_wide(req_wide), .req_addr(req_addr), .req_wdata(req_wdata),
        .busy(busy), .rd_data(rd_data), .rd_valid(rd_valid),
        .bus_addr(bus_addr), .bus_dout(bus_dout), .bus_doe(bus_doe),
        .bus_din(bus_din), .ior_n(ior_n), .iow_n(iow_n), .memr_n(memr_n),
        .memw_n(memw_n)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_strobes(logic wr, logic mem, int k);
        if (k < 33 || k > 82) return 4'b1111;
        case ({mem, wr})
            2'b00: return 4'b0111;
            2'b01: return 4'b1011;
            2'b10: return 4'b1101;
            default: return 4'b1110;
        endcase
    endfunction

    function automatic logic [1:0] exp_oe(logic wr, logic wide, int k);
        if (!wr || k < 29 || k > 92) return 2'b00;
        return wide ? 2'b11 : 2'b01;
    endfunction

    task automatic access(logic wr, logic mem, logic wide,
                          logic [AW-1:0] addr, logic [DW-1:0] data);
        logic [DW-1:0] exp_rd;
        exp_rd = wide ? data : {8'h00, data[7:0]};
        @(negedge clk);
        req = 1'b1; req_wr = wr; req_mem = mem; req_wide = wide;
        req_addr = addr; req_wdata = data; bus_din = ~data;
        @(posedge clk);
        @(negedge clk);
        req = 1'b0;
        req_wdata = ~data;
        for (int k = 0; k <= 95; k++) begin
            // R2 / R9 busy window
            chk("R2 busy", {31'd0, busy}, {31'd0, (k <= 92)});
            // R3 strobe choice and window
            chk("R3 strobes", {28'd0, ior_n, iow_n, memr_n, memw_n},
                {28'd0, exp_strobes(wr, mem, k)});
            // R4 / R6 / R7 lane enables
            chk("R4 R6 R7 doe", {30'd0, bus_doe}, {30'd0, exp_oe(wr, wide, k)});
            if (exp_oe(wr, wide, k) != 2'b00) begin
                if (wide) chk("R4 dout", {16'd0, bus_dout}, {16'd0, data});
                else      chk("R4 dout lo", {24'd0, bus_dout[7:0]}, {24'd0, data[7:0]});
            end
            if (k <= 92) chk("R2 addr", {12'd0, bus_addr}, {12'd0, addr});
            // R5 valid pulse
            chk("R5 rd_valid", {31'd0, rd_valid}, {31'd0, (!wr && k == 93)});
            if (!wr && k == 93) chk("R5 R7 rd_data", {16'd0, rd_data}, {16'd0, exp_rd});
            // read data only good in the four cycles before the capture edge
            bus_din = (k >= 79 && k <= 82) ? data : ~data;
            // R8 stray request mid-cycle
            if (k == 40) begin
                req = 1'b1; req_wr = ~wr; req_mem = ~mem; req_addr = ~addr;
            end
            if (k == 41) req = 1'b0;
            @(negedge clk);
        end
    endtask

    initial begin
        #2_000_000;
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1357));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk("R1 strobes", {28'd0, ior_n, iow_n, memr_n, memw_n}, 32'hF);
        chk("R1 busy", {31'd0, busy}, 32'd0);
        chk("R1 doe", {30'd0, bus_doe}, 32'd0);
        chk("R1 rd_valid", {31'd0, rd_valid}, 32'd0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 idle after reset", {31'd0, busy}, 32'd0);
        // directed: every type at both widths (R3, R7, R9)
        for (int t = 0; t < 8; t++)
            access(t[0], t[1], t[2], 20'hA5000 + AW'(t), 16'hC3A0 + 16'(t));
        // directed corner data values
        access(1'b0, 1'b0, 1'b1, 20'hFFFFF, 16'hFFFF);
        access(1'b1, 1'b1, 1'b0, 20'h00000, 16'h8001);
        // random mix
        for (int n = 0; n < 20; n++)
            access(1'($urandom), 1'($urandom), 1'($urandom),
                   AW'($urandom), DW'($urandom));
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule